// File: doc/BRIEF.md
# Dual-Protocol Serial Register Port

This block is the slave-side front end that lets an external host read and write an internal byte-wide register file over either a two-wire I2C bus or a four-wire SPI link. Both protocols share one set of pins. The serial clock pin and the serial data-in pin serve both modes. A third pin is read as the low bit of the I2C device address, and the same pin carries the SPI data output. An active-low chip select chooses SPI. While chip select is high, the block listens for I2C, unless a configuration input locks the I2C decoder out.

Every pin input passes through a two-flop synchronizer, and the block oversamples the buses from its own system clock. On I2C the block is always a slave. It tracks START and STOP, compares the 7-bit address against `110100` plus the strapped bit, and acknowledges by pulling SDA low. A write takes a register pointer byte first, then data bytes, and the pointer advances after each data byte. On SPI the first byte is a command: bit 7 set means read, bit 7 clear means write, and bits 6..0 give the register address. Later bytes move data with the address advancing after each byte. Both protocols reach the same storage.

Top module: `srp_port`

## Requirements
- R1: After a synchronous reset, `sda_pull_o`, `sdo_oe_o` and `bus_busy_o` are all 0.
- R2: With I2C enabled, SDA falling while SCL is high sets `bus_busy_o`, and SDA rising while SCL is high clears it.
- R3: After a START, an address byte whose upper 7 bits equal `110100` followed by the level of `pin_ad_i` is acknowledged. The block pulls SDA low during the ninth clock. Both the strap-0 address (0x68) and the strap-1 address (0x69) work.
- R4: An address byte that does not match gets no acknowledge. Every later byte until the next START is also left unacknowledged and writes nothing.
- R5: In an I2C write, the first byte after the address is the register pointer. Each following data byte is stored at the pointer, gets an acknowledge, and advances the pointer by one.
- R6: In an I2C read (address bit 0 = 1), bytes are sent MSB first starting at the current pointer. A master ACK (SDA low on the ninth clock) makes the block send the next register. A master NACK ends the read, and SDA stays released.
- R7: In SPI, the first byte's bit 7 selects read (1) or write (0), and bits 6..0 give the start address. In a write, each later byte is stored and the address advances by one.
- R8: In an SPI read, data is shifted out on `sdo_o` MSB first, with a new bit after each SCLK falling edge and consecutive registers in a burst. `sdo_oe_o` is 0 whenever chip select is high.
- R9: While `i2c_dis_i` is 1, bus activity is never decoded as I2C, even with chip select high. There is no acknowledge, no busy flag, no write, and SDA is never pulled.
- R10: While chip select is low, SDA is never pulled and I2C START does not set busy.
- R11: Both protocols access one register file. Data written over SPI reads back over I2C, and the reverse also holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Chip select, low selects SPI |
| scl_i | input | 1 | I2C clock / SPI clock pin level |
| sda_i | input | 1 | I2C data / SPI data-in pin level |
| pin_ad_i | input | 1 | Address-strap level (I2C address bit 0) |
| i2c_dis_i | input | 1 | Configuration bit that locks out I2C decoding |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| sdo_o | output | 1 | SPI serial data output value |
| sdo_oe_o | output | 1 | SPI data output enable on the shared strap pin |
| bus_busy_o | output | 1 | I2C bus busy between START and STOP |

## Verification
The checker watches on every cycle that SDA is never pulled while I2C is locked out or chip select is low, and that the SPI output is disabled when chip select is high. It also checks that a START on the synchronized lines sets busy and a STOP clears it, that the I2C path never writes in SPI mode, and that the outputs are idle after reset. Address matching with either strap level, pointer auto-increment, MSB-first ordering, the master's ACK/NACK ending a read, and data shared between the two protocols can only be shown by the bench's directed transactions at the pins.

// File: rtl/srp_pkg.sv
package srp_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    I_IDLE, I_ADDR, I_PTR, I_WDATA, I_TX, I_IGNORE
  } i2c_st_t;

  typedef enum logic [1:0] {
    S_CMD, S_RD, S_WR
  } spi_st_t;
endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= RST_VAL;
        else if (g == 0) chain[g] <= d;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/srp_regfile.sv
module srp_regfile #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/srp_i2c_eng.sv
module srp_i2c_eng
  import srp_pkg::*;
#(
  parameter int         AW      = 7,
  parameter logic [5:0] DEV_HI  = 6'b110100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              addr_lsb,
  input  logic [DATA_W-1:0] rdata,
  output logic              we,
  output logic [AW-1:0]     ptr,
  output logic [DATA_W-1:0] wdata,
  output logic              pull,
  output logic              busy
);
  logic              scl_p, sda_p;
  i2c_st_t           st;
  logic [3:0]        bcnt;
  logic              ackph;
  logic [DATA_W-1:0] sh, tx;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  wire scl_rise = scl_s & ~scl_p;
  wire scl_fall = ~scl_s & scl_p;
  wire start_c  = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_c   = scl_s & scl_p & ~sda_p & sda_s;

  assign wdata = sh;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st    <= I_IDLE;
      bcnt  <= '0;
      ackph <= 1'b0;
      sh    <= '0;
      tx    <= '0;
      ptr   <= '0;
      pull  <= 1'b0;
      busy  <= 1'b0;
      we    <= 1'b0;
    end else begin
      we <= 1'b0;
      if (start_c) begin
        busy  <= 1'b1;
        st    <= I_ADDR;
        bcnt  <= '0;
        ackph <= 1'b0;
        pull  <= 1'b0;
      end else if (stop_c) begin
        busy <= 1'b0;
        st   <= I_IDLE;
        pull <= 1'b0;
      end else begin
        case (st)
          I_ADDR, I_PTR, I_WDATA: begin
            if (scl_rise && !ackph && bcnt < 4'd8) begin
              sh   <= {sh[DATA_W-2:0], sda_s};
              bcnt <= bcnt + 4'd1;
            end
            if (scl_fall && !ackph && bcnt == 4'd8) begin
              ackph <= 1'b1;
              if (st == I_ADDR) begin
                if (sh[7:1] == {DEV_HI, addr_lsb}) pull <= 1'b1;
                else st <= I_IGNORE;
              end else if (st == I_PTR) begin
                pull <= 1'b1;
                ptr  <= sh[AW-1:0];
              end else begin
                pull <= 1'b1;
                we   <= 1'b1;
              end
            end else if (scl_fall && ackph) begin
              ackph <= 1'b0;
              pull  <= 1'b0;
              bcnt  <= '0;
              if (st == I_ADDR) begin
                if (sh[0]) begin
                  st   <= I_TX;
                  pull <= ~rdata[7];
                  tx   <= {rdata[6:0], 1'b0};
                  bcnt <= 4'd1;
                end else begin
                  st <= I_PTR;
                end
              end else if (st == I_PTR) begin
                st <= I_WDATA;
              end else begin
                ptr <= ptr + 1'b1;
              end
            end
          end
          I_TX: begin
            if (scl_fall) begin
              if (bcnt < 4'd8) begin
                pull <= ~tx[7];
                tx   <= {tx[6:0], 1'b0};
                bcnt <= bcnt + 4'd1;
              end else if (bcnt == 4'd8) begin
                pull <= 1'b0;
                bcnt <= 4'd9;
              end else if (bcnt == 4'd10) begin
                pull <= ~rdata[7];
                tx   <= {rdata[6:0], 1'b0};
                bcnt <= 4'd1;
              end
            end
            if (scl_rise && bcnt == 4'd9) begin
              if (!sda_s) begin
                ptr  <= ptr + 1'b1;
                bcnt <= 4'd10;
              end else begin
                st <= I_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/srp_spi_eng.sv
module srp_spi_eng
  import srp_pkg::*;
#(
  parameter int AW = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              sclk_s,
  input  logic              sdi_s,
  input  logic [DATA_W-1:0] rdata,
  output logic              we,
  output logic [AW-1:0]     waddr,
  output logic [DATA_W-1:0] wdata,
  output logic [AW-1:0]     ptr,
  output logic              sdo,
  output logic              sdo_oe
);
  logic              sclk_p;
  spi_st_t           ph;
  logic [2:0]        cnt;
  logic [DATA_W-1:0] sh, tx;

  always_ff @(posedge clk) begin
    if (rst) sclk_p <= 1'b0;
    else     sclk_p <= sclk_s;
  end

  wire rise = sclk_s & ~sclk_p;
  wire fall = ~sclk_s & sclk_p;
  wire [DATA_W-1:0] nxt = {sh[DATA_W-2:0], sdi_s};

  always_ff @(posedge clk) begin
    if (rst || !sel) begin
      ph     <= S_CMD;
      cnt    <= '0;
      sh     <= '0;
      tx     <= '0;
      ptr    <= '0;
      waddr  <= '0;
      wdata  <= '0;
      we     <= 1'b0;
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
    end else begin
      we <= 1'b0;
      if (rise) begin
        sh <= nxt;
        if (cnt == 3'd7) begin
          cnt <= '0;
          case (ph)
            S_CMD: begin
              ptr    <= nxt[AW-1:0];
              ph     <= nxt[7] ? S_RD : S_WR;
              sdo_oe <= nxt[7];
            end
            S_WR: begin
              we    <= 1'b1;
              wdata <= nxt;
              waddr <= ptr;
              ptr   <= ptr + 1'b1;
            end
            default: ptr <= ptr + 1'b1;
          endcase
        end else begin
          cnt <= cnt + 3'd1;
        end
      end
      if (fall && ph == S_RD) begin
        if (cnt == 3'd0) begin
          sdo <= rdata[7];
          tx  <= {rdata[6:0], 1'b0};
        end else begin
          sdo <= tx[7];
          tx  <= {tx[6:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/srp_port.sv
module srp_port
  import srp_pkg::*;
#(
  parameter int         REG_AW      = 7,
  parameter int         SYNC_STAGES = 2,
  parameter logic [5:0] DEV_ADDR_HI = 6'b110100
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n_i,
  input  logic scl_i,
  input  logic sda_i,
  input  logic pin_ad_i,
  input  logic i2c_dis_i,
  output logic sda_pull_o,
  output logic sdo_o,
  output logic sdo_oe_o,
  output logic bus_busy_o
);
  logic [3:0] pins_s;
  logic cs_s, scl_s, sda_s, ad_s;

  srp_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1110)) u_sync (
    .clk(clk), .rst(rst),
    .d({cs_n_i, scl_i, sda_i, pin_ad_i}),
    .q(pins_s)
  );
  assign {cs_s, scl_s, sda_s, ad_s} = pins_s;

  wire i2c_en  = cs_s & ~i2c_dis_i;
  wire spi_sel = ~cs_s;

  logic              i2c_we, spi_we, rf_we;
  logic [REG_AW-1:0] i2c_ptr, spi_ptr, spi_waddr, rf_waddr, rf_raddr;
  logic [DATA_W-1:0] i2c_wdata, spi_wdata, rf_wdata, rf_rdata;

  srp_i2c_eng #(.AW(REG_AW), .DEV_HI(DEV_ADDR_HI)) u_i2c (
    .clk(clk), .rst(rst), .en(i2c_en),
    .scl_s(scl_s), .sda_s(sda_s), .addr_lsb(ad_s),
    .rdata(rf_rdata), .we(i2c_we), .ptr(i2c_ptr), .wdata(i2c_wdata),
    .pull(sda_pull_o), .busy(bus_busy_o)
  );

  srp_spi_eng #(.AW(REG_AW)) u_spi (
    .clk(clk), .rst(rst), .sel(spi_sel),
    .sclk_s(scl_s), .sdi_s(sda_s), .rdata(rf_rdata),
    .we(spi_we), .waddr(spi_waddr), .wdata(spi_wdata), .ptr(spi_ptr),
    .sdo(sdo_o), .sdo_oe(sdo_oe_o)
  );

  always_comb begin
    if (spi_sel) begin
      rf_we    = spi_we;
      rf_waddr = spi_waddr;
      rf_wdata = spi_wdata;
      rf_raddr = spi_ptr;
    end else begin
      rf_we    = i2c_we;
      rf_waddr = i2c_ptr;
      rf_wdata = i2c_wdata;
      rf_raddr = i2c_ptr;
    end
  end

  srp_regfile #(.AW(REG_AW), .DW(DATA_W)) u_rf (
    .clk(clk), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .raddr(rf_raddr), .rdata(rf_rdata)
  );
endmodule

// File: rtl/srp_port_chk.sv
module srp_port_chk (
  input logic clk,
  input logic rst,
  input logic cs_s,
  input logic scl_s,
  input logic sda_s,
  input logic i2c_dis,
  input logic sda_pull,
  input logic sdo_oe,
  input logic busy,
  input logic i2c_we
);
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!sda_pull && !sdo_oe && !busy)); // R1

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (cs_s && !i2c_dis && $past(scl_s) && scl_s && $past(sda_s) && !sda_s) |=> busy); // R2

  AST_STOP_CLEARS_BUSY: assert property (@(posedge clk) disable iff (rst)
    ($past(scl_s) && scl_s && !$past(sda_s) && sda_s) |=> !busy); // R2

  AST_DIS_NO_PULL: assert property (@(posedge clk) disable iff (rst)
    i2c_dis |=> !sda_pull); // R9

  AST_DIS_NO_BUSY: assert property (@(posedge clk) disable iff (rst)
    i2c_dis |=> !busy); // R9

  AST_CS_NO_PULL: assert property (@(posedge clk) disable iff (rst)
    !cs_s |=> (!sda_pull && !i2c_we)); // R10

  AST_SDO_IDLE: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> !sdo_oe); // R8
endmodule

bind srp_port srp_port_chk u_chk (
  .clk(clk), .rst(rst), .cs_s(cs_s), .scl_s(scl_s), .sda_s(sda_s),
  .i2c_dis(i2c_dis_i), .sda_pull(sda_pull_o), .sdo_oe(sdo_oe_o),
  .busy(bus_busy_o), .i2c_we(i2c_we)
);

// File: tb/tb_srp_port.sv
module tb_srp_port;
  localparam int H  = 20;
  localparam int HS = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, scl = 1'b1, sda_m = 1'b1, pin_ad = 1'b0, i2c_dis = 1'b0;
  logic sda_pull, sdo, sdo_oe, busy;
  wire  sda_line = sda_m & ~sda_pull;

  int n_tests = 0, n_fail = 0;
  logic pull_seen = 1'b0, mon = 1'b0;

  always #10 clk = ~clk;

  srp_port dut (
    .clk(clk), .rst(rst), .cs_n_i(cs_n), .scl_i(scl), .sda_i(sda_line),
    .pin_ad_i(pin_ad), .i2c_dis_i(i2c_dis), .sda_pull_o(sda_pull),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .bus_busy_o(busy)
  );

  always @(posedge clk) if (mon && sda_pull) pull_seen <= 1'b1;

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic i_start();
    sda_m = 1'b1; wt(H); scl = 1'b1; wt(H);
    sda_m = 1'b0; wt(H); scl = 1'b0; wt(2);
  endtask

  task automatic i_stop();
    sda_m = 1'b0; wt(H); scl = 1'b1; wt(H); sda_m = 1'b1; wt(H);
  endtask

  task automatic i_wr(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(H); scl = 1'b1; wt(H); scl = 1'b0; wt(2);
    end
    sda_m = 1'b1; wt(H); scl = 1'b1; wt(H/2);
    ack = sda_line; wt(H/2); scl = 1'b0; wt(2);
  endtask

  task automatic i_rd(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(H); scl = 1'b1; wt(H/2); b[i] = sda_line; wt(H/2); scl = 1'b0; wt(2);
    end
    sda_m = ~mack; wt(H); scl = 1'b1; wt(H); scl = 1'b0; wt(2);
    sda_m = 1'b1;
  endtask

  task automatic s_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      sda_m = tx[i]; wt(HS); scl = 1'b1; rx[i] = sdo; wt(HS); scl = 1'b0;
    end
  endtask

  task automatic s_begin();
    scl = 1'b0; wt(4); cs_n = 1'b0; wt(HS);
  endtask

  task automatic s_end();
    wt(HS); cs_n = 1'b1; wt(4); scl = 1'b1; sda_m = 1'b1; wt(4*HS);
  endtask

  task automatic spi_read1(input logic [6:0] a, output logic [7:0] d);
    logic [7:0] dum;
    s_begin(); s_byte({1'b1, a}, dum); s_byte(8'h00, d); s_end();
  endtask

  task automatic t_reset();
    chk(sda_pull == 1'b0, "R1 sda_pull after reset", sda_pull, 0);
    chk(sdo_oe == 1'b0, "R1 sdo_oe after reset", sdo_oe, 0);
    chk(busy == 1'b0, "R1 busy after reset", busy, 0);
  endtask

  task automatic t_busy();
    i_start(); wt(4);
    chk(busy == 1'b1, "R2 busy after START", busy, 1);
    i_stop(); wt(4);
    chk(busy == 1'b0, "R2 busy after STOP", busy, 0);
  endtask

  task automatic t_i2c_write();
    logic a0, a1, a2, a3;
    i_start(); i_wr(8'hD0, a0); i_wr(8'h10, a1); i_wr(8'hA5, a2); i_wr(8'h3C, a3); i_stop();
    chk(a0 == 1'b0, "R3 address 0x68 acknowledged", a0, 0);
    chk(a1 == 1'b0, "R5 pointer byte acknowledged", a1, 0);
    chk(a2 == 1'b0 && a3 == 1'b0, "R5 data bytes acknowledged", {a2, a3}, 0);
  endtask

  task automatic t_i2c_read();
    logic a0, a1, a2;
    logic [7:0] d0, d1;
    i_start(); i_wr(8'hD0, a0); i_wr(8'h10, a1);
    i_start(); i_wr(8'hD1, a2);
    i_rd(1'b1, d0); i_rd(1'b0, d1);
    wt(4);
    chk(sda_pull == 1'b0, "R6 SDA released after NACK", sda_pull, 0);
    i_stop();
    chk(a2 == 1'b0, "R3 read address acknowledged", a2, 0);
    chk(d0 == 8'hA5, "R6 first read byte (R5 write at 0x10)", d0, 8'hA5);
    chk(d1 == 8'h3C, "R6 second byte after ACK (R5 increment)", d1, 8'h3C);
  endtask

  task automatic t_mismatch();
    logic a0, a1, a2;
    logic [7:0] d;
    i_start(); i_wr(8'hD2, a0); i_wr(8'h10, a1); i_wr(8'hFF, a2); i_stop();
    chk(a0 == 1'b1, "R4 address 0x69 not acknowledged with strap 0", a0, 1);
    chk(a1 == 1'b1 && a2 == 1'b1, "R4 later bytes not acknowledged", {a1, a2}, 3);
    spi_read1(7'h10, d);
    chk(d == 8'hA5, "R4 register unchanged after mismatched write", d, 8'hA5);
  endtask

  task automatic t_strap1();
    logic a0, a1, a2;
    logic [7:0] d;
    pin_ad = 1'b1; wt(8);
    i_start(); i_wr(8'hD2, a0); i_wr(8'h30, a1); i_wr(8'h5A, a2); i_stop();
    chk(a0 == 1'b0, "R3 address 0x69 acknowledged with strap 1", a0, 0);
    spi_read1(7'h30, d);
    chk(d == 8'h5A, "R11 I2C write read back over SPI", d, 8'h5A);
    pin_ad = 1'b0; wt(8);
  endtask

  task automatic t_spi();
    logic [7:0] r, d0, d1;
    s_begin(); s_byte(8'h20, r); s_byte(8'h11, r); s_byte(8'h22, r); s_end();
    s_begin(); s_byte(8'hA0, r); s_byte(8'h00, d0); s_byte(8'h00, d1); s_end();
    chk(d0 == 8'h11, "R7 SPI write then R8 SPI read first byte", d0, 8'h11);
    chk(d1 == 8'h22, "R7 address increment and R8 burst read", d1, 8'h22);
    chk(sdo_oe == 1'b0, "R8 sdo_oe low with chip select high", sdo_oe, 0);
  endtask

  task automatic t_shared();
    logic a0, a1, a2;
    logic [7:0] d;
    i_start(); i_wr(8'hD0, a0); i_wr(8'h21, a1);
    i_start(); i_wr(8'hD1, a2); i_rd(1'b0, d); i_stop();
    chk(d == 8'h22, "R11 SPI write read back over I2C", d, 8'h22);
  endtask

  task automatic t_cs_low();
    logic a0;
    pull_seen = 1'b0; mon = 1'b1;
    cs_n = 1'b0; wt(8);
    i_start(); wt(4);
    chk(busy == 1'b0, "R10 START ignored with chip select low", busy, 0);
    i_wr(8'hD0, a0); i_stop();
    chk(a0 == 1'b1, "R10 no acknowledge with chip select low", a0, 1);
    chk(pull_seen == 1'b0, "R10 SDA never pulled", pull_seen, 0);
    cs_n = 1'b1; mon = 1'b0; wt(8);
  endtask

  task automatic t_disable();
    logic a0, a1, a2;
    logic [7:0] d;
    i2c_dis = 1'b1; pull_seen = 1'b0; mon = 1'b1; wt(4);
    i_start(); wt(4);
    chk(busy == 1'b0, "R9 START ignored while I2C locked out", busy, 0);
    i_wr(8'hD0, a0); i_wr(8'h10, a1); i_wr(8'h77, a2); i_stop();
    chk(a0 == 1'b1 && a1 == 1'b1 && a2 == 1'b1, "R9 no acknowledge while locked out", {a0, a1, a2}, 7);
    chk(pull_seen == 1'b0, "R9 SDA never pulled while locked out", pull_seen, 0);
    mon = 1'b0; i2c_dis = 1'b0; wt(4);
    spi_read1(7'h10, d);
    chk(d == 8'hA5, "R9 no write while locked out", d, 8'hA5);
  endtask

  initial begin
    wt(5); rst = 1'b0; wt(5);
    t_reset();
    t_busy();
    t_i2c_write();
    t_i2c_read();
    t_mismatch();
    t_strap1();
    t_spi();
    t_shared();
    t_cs_low();
    t_disable();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule